// File: doc/BRIEF.md
# Glitch-Free Multi-Source Clock Selector

This block picks one of several unrelated clock sources, for example a crystal oscillator, a PLL output and a slow always-on clock, and drives a single system clock from it. Moving from one source to another never produces a shortened high or low pulse. Each source has its own small controller that runs on that source's clock. A controller opens its clock gate only after every other controller reports that its gate is shut. The gated clocks are then merged by an OR cell that is placed as its own instance.

Software or a power manager drives a binary source index on the select input. It then waits until the busy flag falls, after which the one-hot status names the new source. A parameter chooses which source is already running when the per-source resets are released. A source stops only on the falling edge of its own clock, so its last high phase is always complete. The merged clock stays low from the moment the old source stops until the new source starts.

Top module: `clksw_top`

## Requirements
- R1: When all resets are released, `active_o` is the one-hot code of `DEFAULT_SRC` (3'b001 with defaults), `busy_o` is 0, and `clk_o` runs at the period of that source.
- R2: At no time is more than one bit of `active_o` set. A source is enabled only after all the other sources report that their gates are closed.
- R3: When `sel_i` names a valid source that is not active, `busy_o` goes high at once and stays high until `active_o` equals the one-hot code of that source.
- R4: After a handover, `clk_o` has the period of the newly selected source.
- R5: While a source is active, `clk_o` is high for each whole high phase of that source. Its high time equals that source's high time.
- R6: `clk_o` never shows a high or low pulse shorter than the shortest half period among the sources.
- R7: While `active_o` is zero, during a handover, `clk_o` stays low and has no rising edge.
- R8: A select value equal to the active source is ignored: `busy_o` stays 0 and `active_o` does not change.
- R9: A select value of `N_SRC` or more (code 3 with three sources) is ignored: the current source keeps running and `busy_o` stays 0.
- R10: `sel_i` is a binary index. Value k selects `clk_src_i[k]`, and bit k of `active_o` reports it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src_i | input | N_SRC | Source clocks, bit k is source k |
| rst_n_i | input | N_SRC | Active-low asynchronous reset for each source's controller |
| sel_i | input | SEL_W | Binary index of the requested source, asynchronous |
| clk_o | output | 1 | Merged glitch-free system clock |
| active_o | output | N_SRC | One-hot flag of the source whose gate is open |
| busy_o | output | 1 | High while a valid request differs from the active source |

## Verification
Two events can meet in the same step. One is the completion of a handover, where busy falls as the new gate opens. The other is the ignore path for a request that repeats the active source or uses an unused code. The stimulus table therefore places a repeated select and an out-of-range select immediately after a completed switch. Each is judged by `busy_o` staying low at once and after a settling wait, with `active_o` unchanged. Independently, a pulse-width monitor and a monitor for edges during the gap watch every edge of `clk_o` across all switches.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    typedef enum logic {
        DOM_OFF = 1'b0,
        DOM_ON  = 1'b1
    } dom_state_e;

    typedef struct packed {
        dom_state_e st;
    } dom_regs_t;

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d.s1 = d_i;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            r_q.s1 <= RST_VAL;
            r_q.s2 <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign q_o = r_q.s2;

endmodule

// File: rtl/clksw_gate.sv
module clksw_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);

    logic lat_q;

    // enable passes only while the clock is low
    always_latch begin
        if (!clk_i) begin
            lat_q <= en_i;
        end
    end

    assign gclk_o = clk_i & lat_q;

endmodule

// File: rtl/clksw_or.sv
module clksw_or #(
    parameter int W = 2
) (
    input  logic [W-1:0] in_i,
    output logic         out_o
);

    assign out_o = |in_i;

endmodule

// File: rtl/clksw_domain.sv
module clksw_domain
    import clksw_pkg::*;
#(
    parameter int N_SRC       = 3,
    parameter int SEL_W       = 2,
    parameter int IDX         = 0,
    parameter int DEFAULT_SRC = 0
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [N_SRC-1:0] en_all_i,
    output logic             en_o,
    output logic             gclk_o
);

    localparam logic [N_SRC-1:0] OWN_MASK = N_SRC'(1) << IDX;
    localparam logic [N_SRC-1:0] EN_RST   = N_SRC'(1) << DEFAULT_SRC;
    localparam logic [SEL_W-1:0] SEL_RST  = SEL_W'(DEFAULT_SRC);
    localparam logic [SEL_W-1:0] MY_CODE  = SEL_W'(IDX);
    localparam logic [SEL_W:0]   SEL_LIM  = (SEL_W+1)'(N_SRC);
    localparam dom_state_e       ST_RST   = (IDX == DEFAULT_SRC) ? DOM_ON : DOM_OFF;
    localparam logic             GATE_RST = (IDX == DEFAULT_SRC);

    logic [SEL_W-1:0] sel_s;
    logic [N_SRC-1:0] en_s;
    logic             others_off;
    logic             sel_hit;
    logic             sel_ok;
    dom_regs_t        cur_q, nxt_d;
    logic             en_q, en_d;

    clksw_sync #(.W(SEL_W), .RST_VAL(SEL_RST)) u_sel_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     (sel_i),
        .q_o     (sel_s)
    );

    clksw_sync #(.W(N_SRC), .RST_VAL(EN_RST)) u_en_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     (en_all_i),
        .q_o     (en_s)
    );

    assign others_off = ~|(en_s & ~OWN_MASK);
    assign sel_hit    = (sel_s == MY_CODE);
    assign sel_ok     = ({1'b0, sel_s} < SEL_LIM);

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            DOM_OFF: if (sel_hit && others_off) nxt_d.st = DOM_ON;
            DOM_ON:  if (sel_ok && !sel_hit)    nxt_d.st = DOM_OFF;
            default: nxt_d.st = DOM_OFF;
        endcase
        en_d = (cur_q.st == DOM_ON);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) cur_q.st <= ST_RST;
        else          cur_q    <= nxt_d;
    end

    // gate enable moves on the falling edge only
    always_ff @(negedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) en_q <= GATE_RST;
        else          en_q <= en_d;
    end

    clksw_gate u_gate (
        .clk_i  (clk_i),
        .en_i   (en_q),
        .gclk_o (gclk_o)
    );

    assign en_o = en_q;

endmodule

// File: rtl/clksw_top.sv
module clksw_top #(
    parameter int N_SRC       = 3,
    parameter int DEFAULT_SRC = 0,
    localparam int SEL_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] clk_src_i,
    input  logic [N_SRC-1:0] rst_n_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             clk_o,
    output logic [N_SRC-1:0] active_o,
    output logic             busy_o
);

    localparam logic [SEL_W:0] SEL_LIM = (SEL_W+1)'(N_SRC);

    logic [N_SRC-1:0] en_w;
    logic [N_SRC-1:0] gclk_w;
    logic [N_SRC-1:0] tgt_w;

    for (genvar g = 0; g < N_SRC; g++) begin : g_dom
        clksw_domain #(
            .N_SRC       (N_SRC),
            .SEL_W       (SEL_W),
            .IDX         (g),
            .DEFAULT_SRC (DEFAULT_SRC)
        ) u_dom (
            .clk_i    (clk_src_i[g]),
            .rst_n_i  (rst_n_i[g]),
            .sel_i    (sel_i),
            .en_all_i (en_w),
            .en_o     (en_w[g]),
            .gclk_o   (gclk_w[g])
        );
    end

    clksw_or #(.W(N_SRC)) u_merge (
        .in_i  (gclk_w),
        .out_o (clk_o)
    );

    always_comb begin
        tgt_w = en_w;
        if ({1'b0, sel_i} < SEL_LIM) tgt_w = N_SRC'(1) << sel_i;
        busy_o = (tgt_w != en_w);
    end

    assign active_o = en_w;

endmodule

// File: rtl/clksw_chk.sv
module clksw_chk #(
    parameter int N_SRC = 3,
    parameter int SEL_W = 2
) (
    input logic [N_SRC-1:0] clk_src_i,
    input logic [N_SRC-1:0] rst_n_i,
    input logic [SEL_W-1:0] sel_i,
    input logic             clk_o,
    input logic [N_SRC-1:0] active_o,
    input logic             busy_o
);

    logic all_rst_n;
    assign all_rst_n = &rst_n_i;

    for (genvar k = 0; k < N_SRC; k++) begin : g_chk
        // R2
        excl_onehot_chk: assert property (@(posedge clk_src_i[k]) disable iff (!all_rst_n)
            $onehot0(active_o));

        // R5
        gate_pass_chk: assert property (@(negedge clk_src_i[k]) disable iff (!all_rst_n)
            active_o[k] |-> clk_o);

        // R7
        gap_low_chk: assert property (@(negedge clk_src_i[k]) disable iff (!all_rst_n)
            (active_o == '0) |-> !clk_o);

        // R8
        same_keep_chk: assert property (@(posedge clk_src_i[k]) disable iff (!all_rst_n)
            (active_o[k] && (sel_i == SEL_W'(k))) |=> active_o[k]);
    end

endmodule

bind clksw_top clksw_chk #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_chk (
    .clk_src_i (clk_src_i),
    .rst_n_i   (rst_n_i),
    .sel_i     (sel_i),
    .clk_o     (clk_o),
    .active_o  (active_o),
    .busy_o    (busy_o)
);

// File: tb/tb_clksw_top.sv
`timescale 1ns/1ps
module tb_clksw_top;

    localparam int NS   = 3;
    localparam int NROW = 8;

    logic [NS-1:0] clk_src;
    logic [NS-1:0] rst_n;
    logic [1:0]    sel;
    logic          clk_o;
    logic [NS-1:0] active;
    logic          busy;

    clksw_top #(.N_SRC(NS), .DEFAULT_SRC(0)) dut (
        .clk_src_i (clk_src),
        .rst_n_i   (rst_n),
        .sel_i     (sel),
        .clk_o     (clk_o),
        .active_o  (active),
        .busy_o    (busy)
    );

    // source 0 is the 50 MHz bench clock; 1 is faster, 2 is slow
    initial begin clk_src[0] = 1'b0; forever #10 clk_src[0] = ~clk_src[0]; end
    initial begin clk_src[1] = 1'b0; forever #7  clk_src[1] = ~clk_src[1]; end
    initial begin clk_src[2] = 1'b0; forever #31 clk_src[2] = ~clk_src[2]; end

    localparam logic [1:0]    TAB_SEL [NROW] = '{2'd1, 2'd2, 2'd0, 2'd2, 2'd1, 2'd3, 2'd1, 2'd0};
    localparam logic [NS-1:0] TAB_ACT [NROW] = '{3'b010, 3'b100, 3'b001, 3'b100, 3'b010, 3'b010, 3'b010, 3'b001};
    localparam int            TAB_PER [NROW] = '{14, 62, 20, 62, 14, 14, 14, 20};

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    bit  mon_on = 1'b0;
    int  short_pulses = 0;
    int  gap_edges    = 0;
    int  excl_errs    = 0;
    longint rise_t = -1;
    longint fall_t = -1;

    task automatic chk(input bit ok, input string req, input longint got, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic measure(output longint per, output longint hi);
        longint t0, t1, t2;
        @(posedge clk_o); t0 = $time;
        @(negedge clk_o); t1 = $time;
        @(posedge clk_o); t2 = $time;
        per = t2 - t0;
        hi  = t1 - t0;
    endtask

    // R6 pulse widths, R7 edges during gap
    always @(posedge clk_o) begin
        if (mon_on) begin
            if (fall_t >= 0 && ($time - fall_t) < 7) short_pulses++;
            if (active == '0) gap_edges++;
        end
        rise_t = $time;
    end
    always @(negedge clk_o) begin
        if (mon_on && rise_t >= 0 && ($time - rise_t) < 7) short_pulses++;
        fall_t = $time;
    end
    // R2 exclusivity seen at the ports
    always @(active) if (mon_on && $countones(active) > 1) excl_errs++;

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        longint per, hi;
        logic [NS-1:0] prev;
        rst_n = '0;
        sel   = 2'd0;
        #100.5;
        rst_n = '1;
        #200;
        mon_on = 1'b1;
        // R1 reset state
        chk(active == 3'b001, "R1 active", active, 3'b001);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        measure(per, hi);
        chk(per == 20, "R1 period", per, 20);
        #0.5;
        prev = 3'b001;

        for (int i = 0; i < NROW; i++) begin
            bit exp_busy;
            int n;
            sel = TAB_SEL[i];
            #1;
            exp_busy = (TAB_ACT[i] != prev);
            if (exp_busy)
                chk(busy == 1'b1, "R3 busy rise", busy, 1);
            else if (TAB_SEL[i] >= 2'd3)
                chk(busy == 1'b0, "R9 busy", busy, 0);
            else
                chk(busy == 1'b0, "R8 busy", busy, 0);
            n = 0;
            while (busy && n < 5000) begin #1; n++; end
            chk(n < 5000 && active == TAB_ACT[i], "R3,R10 active", active, TAB_ACT[i]);
            if (!exp_busy) begin
                #300;
                if (TAB_SEL[i] >= 2'd3)
                    chk(active == prev && !busy, "R9 hold", active, prev);
                else
                    chk(active == prev && !busy, "R8 hold", active, prev);
            end
            measure(per, hi);
            chk(per == TAB_PER[i], "R4 period", per, TAB_PER[i]);
            chk(hi == TAB_PER[i] / 2, "R5 high time", hi, TAB_PER[i] / 2);
            #0.5;
            prev = TAB_ACT[i];
        end

        chk(short_pulses == 0, "R6 short pulses", short_pulses, 0);
        chk(gap_edges == 0, "R7 edges in gap", gap_edges, 0);
        chk(excl_errs == 0, "R2 multiple active", excl_errs, 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule